// File: doc/BRIEF.md
# Ring Signal Phase Sequencer

This block keeps time for a low-frequency ringing waveform. A phase accumulator, clocked by a nominal 19.6608 MHz system clock, advances by a per-frequency step each cycle. The block presents the running phase, a flag for the current half cycle, and the amplitude, offset and frequency codes now in force. A sine lookup, scaling stage or PWM stage downstream uses these outputs to build the waveform.

Control inputs pass through a synchronous latch. While the latch enable is high the block follows the pins. While it is low the block keeps the last values it captured. A new frequency, amplitude or offset code is applied only at a half-cycle boundary (0° or 180°), so the waveform never jumps part-way through a half cycle. Starting always begins at phase 0. Stopping happens either at once or at the next half-cycle boundary, chosen by a mode input. A sync strobe rises a chosen number of clock cycles before each boundary and drops on the boundary itself.

Top module: `ring_phase_seq`

## Requirements
- R1: After reset, active_o, phase_o, polarity_o, sync_o, freq_o, amp_o and off_o are all zero.
- R2: The control view is {en_i, freq_i, amp_i, off_i} directly while le_i is high. While le_i is low, the view holds the values sampled at the last rising clock edge on which le_i was high, and pin changes have no effect on the outputs.
- R3: While active, phase_o advances each cycle by INC(code) modulo 2^ACC_W, where INC(code) = round-half-up(fc × 2^ACC_W / (CLK_HZ × 100)) and fc is the frequency of the active code in hundredths of a hertz.
- R4: Frequency codes, read as a 3-bit value with bit 0 as LSB, map as follows: 0 = 16.67 Hz, 1 = 20, 2 = 25, 3 = 30, 4 = 33.33, 5 = 40, 6 = 50, 7 = 60 Hz. Amplitude codes 0 to 3 stand for 0, 50, 75 and 100 %. Offset code 0 means none, and codes 1 to 3 pick reference 1 to 3. freq_o, amp_o and off_o report these codes unchanged.
- R5: While active, freq_o, amp_o and off_o change only on the edge where polarity_o toggles. On that edge they take the control view.
- R6: When inactive with the view's enable high, the next edge sets active_o and sets phase_o to 0. The codes are loaded from the view.
- R7: With stop_sync_i low, the edge that sees the view's enable low while active clears active_o and phase_o.
- R8: With stop_sync_i high and the view's enable low, the block runs on until the edge where the phase crosses a half-cycle boundary, then clears active_o and phase_o. If enable returns high before that edge, the block keeps running.
- R9: sync_o is high exactly when active and the next half-cycle boundary comes within lead_i edges. It drops in the cycle that polarity_o changes, and it never rises when lead_i is 0.
- R10: When lead_i is at least the half-cycle length in steps, sync_o stays high for the whole active time.
- R11: While inactive, freq_o, amp_o and off_o read 0. polarity_o is 0 in the first half cycle and 1 in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| le_i | input | 1 | Control latch enable, transparent when high |
| en_i | input | 1 | Ringing enable |
| freq_i | input | 3 | Frequency code |
| amp_i | input | 2 | Amplitude code |
| off_i | input | 2 | Offset code |
| stop_sync_i | input | 1 | 1: stop at next half-cycle boundary, 0: stop at once |
| lead_i | input | LEAD_W | Sync lead time in clock cycles |
| phase_o | output | ACC_W | Phase accumulator value |
| polarity_o | output | 1 | Half-cycle flag |
| active_o | output | 1 | Waveform running |
| freq_o | output | 3 | Active frequency code |
| amp_o | output | 2 | Active amplitude code |
| off_o | output | 2 | Active offset code |
| sync_o | output | 1 | Strobe leading each half-cycle boundary |

## Verification
On every cycle the assertions check that the phase steps by the active increment, that the codes stay fixed inside a half cycle, that phase is zero whenever the block starts or stops, and that sync is low when idle or when lead is zero and high on the cycle before each boundary. Some properties can only be shown by the bench's scenarios, because they depend on stimulus history. These are the latch holding its value while pins move, the deferred stop and its cancellation, and the exact cycle count at which sync rises under each lead and frequency. The bench runs a cycle-accurate arithmetic model through every frequency code and compares all outputs on every cycle.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;

  typedef struct packed {
    logic       en;
    logic [2:0] freq;
    logic [1:0] amp;
    logic [1:0] off;
  } ring_ctl_t;

  // ring frequency in hundredths of a hertz for each code
  function automatic longint unsigned freq_centihz(input logic [2:0] code);
    case (code)
      3'd0: return 64'd1667;
      3'd1: return 64'd2000;
      3'd2: return 64'd2500;
      3'd3: return 64'd3000;
      3'd4: return 64'd3333;
      3'd5: return 64'd4000;
      3'd6: return 64'd5000;
      default: return 64'd6000;
    endcase
  endfunction

  // accumulator step, rounded half up
  function automatic longint unsigned phase_inc(input logic [2:0] code,
                                                input int acc_w,
                                                input longint unsigned clk_hz);
    longint unsigned num;
    longint unsigned den;
    num = freq_centihz(code) << acc_w;
    den = clk_hz * 64'd100;
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/ring_ctrl_latch.sv
module ring_ctrl_latch
  import ring_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      le,
  input  ring_ctl_t pins,
  output ring_ctl_t view
);
  ring_ctl_t held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held_q <= '0;
    else if (le) held_q <= pins;
  end

  assign view = le ? pins : held_q;
endmodule

// File: rtl/ring_phase_acc.sv
module ring_phase_acc
  import ring_seq_pkg::*;
#(
  parameter int              ACC_W  = 32,
  parameter longint unsigned CLK_HZ = 64'd19660800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       freq_code,
  input  logic             run,
  input  logic             clear,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] inc_o,
  output logic             cross_o
);
  localparam int NCODE = 8;

  logic [ACC_W-1:0] inc_tab [NCODE];
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  for (genvar g = 0; g < NCODE; g++) begin : g_inc
    localparam longint unsigned STEP = phase_inc(3'(g), ACC_W, CLK_HZ);
    assign inc_tab[g] = ACC_W'(STEP);
  end

  assign inc_o   = inc_tab[freq_code];
  assign sum     = acc_q + inc_o;
  assign cross_o = run && (sum[ACC_W-1] != acc_q[ACC_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (run)   acc_q <= sum;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/ring_sync_gen.sv
module ring_sync_gen #(
  parameter int ACC_W  = 32,
  parameter int LEAD_W = 16
) (
  input  logic              active,
  input  logic [ACC_W-2:0]  acc_low,
  input  logic [ACC_W-1:0]  inc,
  input  logic [LEAD_W-1:0] lead,
  output logic              sync_o
);
  localparam int PW = ACC_W + LEAD_W;

  logic [PW-1:0] half, prod, thr, rem;

  assign half   = PW'(1) << (ACC_W - 1);
  assign prod   = PW'(lead) * PW'(inc);
  assign thr    = (prod > half) ? half : prod;   // clamp to one half cycle
  assign rem    = half - PW'(acc_low);           // distance to next boundary
  assign sync_o = active && (rem <= thr);
endmodule

// File: rtl/ring_phase_seq.sv
module ring_phase_seq
  import ring_seq_pkg::*;
#(
  parameter int              ACC_W  = 32,
  parameter int              LEAD_W = 16,
  parameter longint unsigned CLK_HZ = 64'd19660800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_i,
  input  logic              en_i,
  input  logic [2:0]        freq_i,
  input  logic [1:0]        amp_i,
  input  logic [1:0]        off_i,
  input  logic              stop_sync_i,
  input  logic [LEAD_W-1:0] lead_i,
  output logic [ACC_W-1:0]  phase_o,
  output logic              polarity_o,
  output logic              active_o,
  output logic [2:0]        freq_o,
  output logic [1:0]        amp_o,
  output logic [1:0]        off_o,
  output logic              sync_o
);
  ring_ctl_t        pins, view, act_q;
  logic             run_q;
  logic             start_w, halt_w, load_w, clear_w, cross_w;
  logic [ACC_W-1:0] acc_w, inc_w;

  assign pins = '{en: en_i, freq: freq_i, amp: amp_i, off: off_i};

  ring_ctrl_latch u_latch (
    .clk(clk), .rst_n(rst_n), .le(le_i), .pins(pins), .view(view)
  );

  ring_phase_acc #(.ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) u_acc (
    .clk(clk), .rst_n(rst_n), .freq_code(act_q.freq), .run(run_q),
    .clear(clear_w), .acc_o(acc_w), .inc_o(inc_w), .cross_o(cross_w)
  );

  ring_sync_gen #(.ACC_W(ACC_W), .LEAD_W(LEAD_W)) u_sync (
    .active(run_q), .acc_low(acc_w[ACC_W-2:0]), .inc(inc_w),
    .lead(lead_i), .sync_o(sync_o)
  );

  assign start_w = !run_q && view.en;
  assign halt_w  = run_q && !view.en && (!stop_sync_i || cross_w);
  assign load_w  = start_w || (run_q && cross_w && !halt_w);
  assign clear_w = start_w || halt_w || !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= '0;
    end else begin
      if (start_w)     run_q <= 1'b1;
      else if (halt_w) run_q <= 1'b0;
      if (load_w)      act_q <= view;
    end
  end

  assign phase_o    = acc_w;
  assign polarity_o = acc_w[ACC_W-1];
  assign active_o   = run_q;
  assign freq_o     = run_q ? act_q.freq : 3'd0;
  assign amp_o      = run_q ? act_q.amp  : 2'd0;
  assign off_o      = run_q ? act_q.off  : 2'd0;
endmodule

// File: rtl/ring_phase_seq_chk.sv
module ring_phase_seq_chk #(
  parameter int ACC_W  = 32,
  parameter int LEAD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active_o,
  input logic [ACC_W-1:0]  phase_o,
  input logic              polarity_o,
  input logic [2:0]        freq_o,
  input logic [1:0]        amp_o,
  input logic [1:0]        off_o,
  input logic              sync_o,
  input logic [LEAD_W-1:0] lead_i,
  input logic [ACC_W-1:0]  inc_w,
  input logic              cross_w
);
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && $past(active_o) |-> phase_o == ACC_W'($past(phase_o) + $past(inc_w)));

  p_codes_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && $past(active_o) && (polarity_o == $past(polarity_o))
      |-> $stable(freq_o) && $stable(amp_o) && $stable(off_o));

  p_start_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> phase_o == '0);

  p_stop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> phase_o == '0);

  p_sync_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !sync_o);

  p_sync_lead0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lead_i == '0 |-> !sync_o);

  p_sync_before_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cross_w && lead_i != '0 |-> sync_o);
endmodule

bind ring_phase_seq ring_phase_seq_chk #(.ACC_W(ACC_W), .LEAD_W(LEAD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .active_o(active_o), .phase_o(phase_o),
  .polarity_o(polarity_o), .freq_o(freq_o), .amp_o(amp_o), .off_o(off_o),
  .sync_o(sync_o), .lead_i(lead_i), .inc_w(inc_w), .cross_w(cross_w)
);

// File: tb/ring_phase_seq_tb_top.sv
`timescale 1ns/1ps
module ring_phase_seq_tb_top;
  localparam int              ACC_W  = 12;
  localparam int              LEAD_W = 12;
  localparam longint unsigned CLK_HZ = 64'd19661;
  localparam longint          M      = 64'd1 << ACC_W;
  localparam longint          H      = M / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic le_i = 1'b1, en_i = 1'b0, stop_sync_i = 1'b0;
  logic [2:0] freq_i = '0;
  logic [1:0] amp_i = '0, off_i = '0;
  logic [LEAD_W-1:0] lead_i = '0;
  logic [ACC_W-1:0] phase_o;
  logic polarity_o, active_o, sync_o;
  logic [2:0] freq_o;
  logic [1:0] amp_o, off_o;

  int n_chk = 0, n_err = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ring_phase_seq #(.ACC_W(ACC_W), .LEAD_W(LEAD_W), .CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .le_i(le_i), .en_i(en_i), .freq_i(freq_i),
    .amp_i(amp_i), .off_i(off_i), .stop_sync_i(stop_sync_i), .lead_i(lead_i),
    .phase_o(phase_o), .polarity_o(polarity_o), .active_o(active_o),
    .freq_o(freq_o), .amp_o(amp_o), .off_o(off_o), .sync_o(sync_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R4 frequencies in centihertz, step computed as quotient plus rounding bit
  function automatic longint bench_inc(input int code);
    longint fc, num, den;
    case (code)
      0: fc = 1667; 1: fc = 2000; 2: fc = 2500; 3: fc = 3000;
      4: fc = 3333; 5: fc = 4000; 6: fc = 5000; default: fc = 6000;
    endcase
    num = fc * M;
    den = longint'(CLK_HZ) * 100;
    return num / den + (((num % den) * 2 >= den) ? 1 : 0);
  endfunction

  // reference model, updated on the same edge as the design
  bit     m_held_en, m_run;
  int     m_held_f, m_held_a, m_held_o, m_f, m_a, m_o;
  longint m_acc;

  always @(posedge clk) begin
    bit v_en; int v_f, v_a, v_o; longint nxt; bit crossed;
    if (!rst_n) begin
      m_held_en = 0; m_held_f = 0; m_held_a = 0; m_held_o = 0;
      m_run = 0; m_acc = 0; m_f = 0; m_a = 0; m_o = 0;
    end else begin
      if (le_i) begin
        m_held_en = en_i; m_held_f = freq_i; m_held_a = amp_i; m_held_o = off_i;
      end
      v_en = m_held_en; v_f = m_held_f; v_a = m_held_a; v_o = m_held_o;
      if (!m_run) begin
        if (v_en) begin
          m_run = 1; m_acc = 0; m_f = v_f; m_a = v_a; m_o = v_o;
        end
      end else begin
        nxt = (m_acc + bench_inc(m_f)) % M;
        crossed = ((nxt / H) != (m_acc / H));
        if (!v_en && (!stop_sync_i || crossed)) begin
          m_run = 0; m_acc = 0;
        end else begin
          m_acc = nxt;
          if (crossed) begin m_f = v_f; m_a = v_a; m_o = v_o; end
        end
      end
    end
  end

  function automatic bit exp_sync();
    longint p;
    if (!m_run) return 0;
    for (int k = 1; k <= int'(lead_i); k++) begin
      p = (m_acc + k * bench_inc(m_f)) % M;
      if ((p / H) != (m_acc / H)) return 1;
    end
    return 0;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(phase_o == ACC_W'(m_acc), "R3", "phase", phase_o, m_acc);
      chk(polarity_o == (m_acc >= H), "R11", "polarity", polarity_o, m_acc >= H);
      chk(active_o == m_run, "R6/R7/R8", "active", active_o, m_run);
      chk({freq_o, amp_o, off_o} == (m_run ? {3'(m_f), 2'(m_a), 2'(m_o)} : 7'd0),
          "R5", "codes", {freq_o, amp_o, off_o},
          m_run ? {3'(m_f), 2'(m_a), 2'(m_o)} : 7'd0);
      chk(sync_o == exp_sync(), "R9", "sync", sync_o, exp_sync());
    end
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int cnt;
    edges(4);
    rst_n = 1'b1;
    edges(2);
    @(negedge clk);
    // R1 reset state
    chk(!active_o && phase_o == 0 && !sync_o && !polarity_o, "R1", "state",
        {active_o, sync_o, polarity_o}, 0);
    chk({freq_o, amp_o, off_o} == 0, "R1", "codes", {freq_o, amp_o, off_o}, 0);
    cmp_en = 1'b1;

    // sweep all frequency codes, immediate stop
    lead_i = 5;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #2;
      freq_i = 3'(c); amp_i = 2'(c); off_i = 2'(3 - (c % 4)); en_i = 1'b1;
      edges(1);
      @(negedge clk);
      chk(active_o && phase_o == 0 && freq_o == 3'(c), "R6", "start",
          {active_o, freq_o}, {1'b1, 3'(c)});
      edges(int'(2 * M / bench_inc(c)) + 20);
      en_i = 1'b0;
      edges(1);
      @(negedge clk);
      chk(!active_o && phase_o == 0, "R7", "immediate stop", active_o, 0);
      chk(amp_o == 0 && off_o == 0 && freq_o == 0, "R11", "idle codes",
          {freq_o, amp_o, off_o}, 0);
    end

    // R5 deferral to the half-cycle boundary
    @(posedge clk); #2;
    freq_i = 0; amp_i = 1; off_i = 1; en_i = 1;
    edges(100);
    amp_i = 3; off_i = 2; freq_i = 7;
    edges(1);
    @(negedge clk);
    chk(amp_o == 1 && off_o == 1 && freq_o == 0, "R5", "held mid half",
        {freq_o, amp_o, off_o}, {3'd0, 2'd1, 2'd1});
    cnt = 0;
    while (!polarity_o && cnt < 2000) begin @(negedge clk); cnt++; end
    chk(amp_o == 3 && off_o == 2 && freq_o == 7, "R5", "applied at crossing",
        {freq_o, amp_o, off_o}, {3'd7, 2'd3, 2'd2});

    // R2 latch closed: pin changes ignored
    @(posedge clk); #2;
    le_i = 1'b0;
    en_i = 1'b0; amp_i = 0; freq_i = 0;
    edges(400);
    @(negedge clk);
    chk(active_o && amp_o == 3 && freq_o == 7, "R2", "latched hold",
        {active_o, amp_o}, {1'b1, 2'd3});
    @(posedge clk); #2;
    le_i = 1'b1;
    edges(1);
    @(negedge clk);
    chk(!active_o, "R2", "latch reopened stop", active_o, 0);

    // R8 synchronous stop and cancellation
    @(posedge clk); #2;
    stop_sync_i = 1'b1; freq_i = 1; amp_i = 2; en_i = 1;
    edges(50);
    en_i = 0;
    edges(1);
    @(negedge clk);
    chk(active_o, "R8", "runs until crossing", active_o, 1);
    cnt = 0;
    while (active_o && cnt < 2000) begin @(negedge clk); cnt++; end
    chk(!active_o && phase_o == 0, "R8", "stop at crossing", active_o, 0);
    chk(cnt <= int'(H / bench_inc(1)) + 1, "R8", "stop latency", cnt, H / bench_inc(1));
    @(posedge clk); #2;
    en_i = 1;
    edges(50);
    en_i = 0;
    edges(10);
    en_i = 1;
    edges(1200);
    @(negedge clk);
    chk(active_o, "R8", "cancelled stop", active_o, 1);

    // R10 lead beyond half cycle clamps to continuous sync
    @(posedge clk); #2;
    lead_i = '1;
    cnt = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (active_o && !sync_o) cnt++;
    end
    chk(cnt == 0, "R10", "sync gaps", cnt, 0);

    // R9 zero lead: no sync
    @(posedge clk); #2;
    lead_i = 0;
    cnt = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (sync_o) cnt++;
    end
    chk(cnt == 0, "R9", "sync with zero lead", cnt, 0);

    // R9 long lead at highest frequency
    @(posedge clk); #2;
    lead_i = 40; freq_i = 7;
    edges(800);
    stop_sync_i = 0; en_i = 0;
    edges(3);
    done = 1'b1;
    finish_run();
  end
endmodule